// File: doc/BRIEF.md
# Write-In-Progress Status Read Path

This block is the read-side output selector of a byte-wide nonvolatile memory model. A read is qualified when the active-low chip select and active-low output enable are both low and the active-low write strobe is high. During a qualified read with no programming cycle running, the block passes the array word to the data output. While the write engine reports a programming cycle as busy, the same read returns an end-of-write status word instead.

The status word has two indicator bits. The top bit is the inverse of bit 7 of the last byte written. Bit 6 flips on each new read access. The remaining low bits carry the stored last byte. A busy cycle started by a rejected write gets the same status reads, because the block follows only the busy flag.

All control and status pins are plain levels with no handshake. A separate qualifier output marks when the data output would be driven. Where the physical part would float its pins, the qualifier is low and the data output is zero. Every output is registered and appears one clock after the inputs that produce it.

Top module: `wip_status_rd`

## Requirements
- R1: A read is qualified only while ce_n=0, oe_n=0 and we_n=1. One clock after such a cycle, dout_en is 1. One clock after any other cycle (ce_n=1, oe_n=1, or we_n=0), dout_en is 0 and dout is 0.
- R2: With busy=0, a qualified read returns arr_data as sampled on the same edge, on all eight bits.
- R3: With busy=1, a qualified read returns on dout[7] the inverse of last_data[7].
- R4: With busy=1, a qualified read returns last_data[5:0] on dout[5:0].
- R5: With busy=1, the internal toggle flips once at the start of each read access. The start of an access is the first cycle of a qualified read after a non-qualified cycle. dout[6] shows the value after the flip.
- R6: A one-cycle wr_start pulse clears the toggle to 0, so the first read of a new write cycle returns dout[6]=1. When wr_start and a read start fall in the same cycle, the clear wins and dout[6]=0 for that access.
- R7: A read held qualified over many cycles counts as one access. Its dout[6] stays constant for the whole access.
- R8: With busy=0, the toggle holds its value and reads return true array data. Status polling can start at any point while busy=1, and the toggle then resumes from its held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| busy | input | 1 | Programming cycle in progress, from the write engine |
| wr_start | input | 1 | One-cycle pulse when a new write cycle begins |
| last_data | input | 8 | Last byte written, from the write engine |
| arr_data | input | 8 | Word read from the array |
| dout | output | 8 | Read data or status word |
| dout_en | output | 1 | High where the data pins would be driven |

## Verification
Each result (dout_en, dout and the toggle bit in dout[6]) is due one clock after the edge that samples the stimulus. The bench drives inputs on the falling clock edge and checks on the next falling edge, which is exactly one register stage later. The toggle is predicted by a bench counter that flips on each read start under busy and clears on wr_start. Tests include a wr_start that coincides with a read start, and a read held over several cycles, to confirm which edge counts as an access.

// File: rtl/wip_pkg.sv
package wip_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned POLL_POS = 7;
  localparam int unsigned TOG_POS  = 6;

  typedef enum logic [1:0] {
    SRC_PASS = 2'd0,
    SRC_INV  = 2'd1,
    SRC_TOG  = 2'd2
  } bit_src_e;

  function automatic bit_src_e status_src(input int unsigned pos,
                                          input int unsigned poll_pos,
                                          input int unsigned tog_pos);
    if (pos == poll_pos) return SRC_INV;
    if (pos == tog_pos)  return SRC_TOG;
    return SRC_PASS;
  endfunction
endpackage

// File: rtl/wip_strobe.sv
module wip_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_now,
  output logic rd_rise
);
  logic rd_q;

  assign rd_now  = ~ce_n & ~oe_n & we_n;
  assign rd_rise = rd_now & ~rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_now;
  end

  // R7: a held read produces no further access starts
  assert_single_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> !rd_rise);
endmodule

// File: rtl/wip_toggle.sv
module wip_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic wr_start,
  input  logic rd_rise,
  output logic tog_q,
  output logic tog_nxt
);
  always_comb begin
    if (wr_start)            tog_nxt = 1'b0;
    else if (busy && rd_rise) tog_nxt = ~tog_q;
    else                     tog_nxt = tog_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_nxt;
  end

  assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_rise && !wr_start) |=> (tog_q != $past(tog_q)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !tog_q);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_start) |=> $stable(tog_q));
endmodule

// File: rtl/wip_outmux.sv
module wip_outmux
  import wip_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned PPOS = POLL_POS,
  parameter int unsigned TPOS = TOG_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_now,
  input  logic          busy,
  input  logic          tog_nxt,
  input  logic [DW-1:0] last_data,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic [DW-1:0] status_w;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    localparam bit_src_e SRC = status_src(i, PPOS, TPOS);
    if (SRC == SRC_INV) begin : g_inv
      assign status_w[i] = ~last_data[i];
    end else if (SRC == SRC_TOG) begin : g_tog
      assign status_w[i] = tog_nxt;
    end else begin : g_pass
      assign status_w[i] = last_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_now;
      if (!rd_now)   dout <= '0;
      else if (busy) dout <= status_w;
      else           dout <= arr_data;
    end
  end

  assert_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && busy) |=> (dout[PPOS] == ~$past(last_data[PPOS])));

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && !busy) |=> (dout == $past(arr_data)));
endmodule

// File: rtl/wip_status_rd.sv
module wip_status_rd
  import wip_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned PPOS = POLL_POS,
  parameter int unsigned TPOS = TOG_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          busy,
  input  logic          wr_start,
  input  logic [DW-1:0] last_data,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic rd_now, rd_rise, tog_q, tog_nxt;

  wip_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_now(rd_now), .rd_rise(rd_rise)
  );

  wip_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_start(wr_start),
    .rd_rise(rd_rise), .tog_q(tog_q), .tog_nxt(tog_nxt)
  );

  wip_outmux #(.DW(DW), .PPOS(PPOS), .TPOS(TPOS)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd_now(rd_now), .busy(busy),
    .tog_nxt(tog_nxt), .last_data(last_data), .arr_data(arr_data),
    .dout(dout), .dout_en(dout_en)
  );

  assert_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |=> (!dout_en && dout == '0));

  assert_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n) |=> dout_en);
endmodule

// File: tb/sim_wip_status_rd.sv
`timescale 1ns/1ps
module sim_wip_status_rd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic busy = 1'b0, wr_start = 1'b0;
  logic [7:0] last_data = 8'h00, arr_data = 8'h00;
  logic [7:0] dout;
  logic dout_en;
  int n_chk = 0, n_bad = 0;
  logic tog = 1'b0;

  always #10 clk = ~clk;

  wip_status_rd u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .wr_start(wr_start), .last_data(last_data),
    .arr_data(arr_data), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] status_of(input logic [7:0] ld, input logic t);
    return {~ld[7], t, ld[5:0]};
  endfunction

  // one read access: strobe low for 'len' cycles, checked each cycle, then released
  task automatic rd_access(input string tag, input int len, input logic start_pulse);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    wr_start = start_pulse;
    if (start_pulse) tog = 1'b0;
    else if (busy) tog = ~tog;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      wr_start = 1'b0;
      chk(tag, {dout_en, dout}, {1'b1, busy ? status_of(last_data, tog) : arr_data});
    end
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    chk({tag, " release R1"}, {dout_en, dout}, 9'h000);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    wr_start = 1'b1; tog = 1'b0;
    @(negedge clk);
    wr_start = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset", {dout_en, dout}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_normal();
    busy = 1'b0;
    arr_data = 8'hA5; rd_access("R2 array A5", 1, 1'b0);
    arr_data = 8'h3C; rd_access("R2 array 3C", 2, 1'b0);
    arr_data = 8'hFF; rd_access("R2 array FF", 1, 1'b0);
  endtask

  task automatic t_gating();
    arr_data = 8'h5A;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); chk("R1 ce high", {dout_en, dout}, 9'h000);
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); chk("R1 oe high", {dout_en, dout}, 9'h000);
    oe_n = 1'b0; we_n = 1'b0;
    @(negedge clk); chk("R1 we low", {dout_en, dout}, 9'h000);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_poll();
    last_data = 8'h80; arr_data = 8'h11;
    pulse_start(); busy = 1'b1;
    rd_access("R3 R5 poll 80 first", 1, 1'b0);
    last_data = 8'h7F;
    rd_access("R3 R4 poll 7F", 1, 1'b0);
    last_data = 8'h2A;
    rd_access("R4 R5 poll 2A", 1, 1'b0);
    rd_access("R5 poll again", 1, 1'b0);
  endtask

  task automatic t_hold();
    rd_access("R7 held read", 5, 1'b0);
    rd_access("R7 after held", 1, 1'b0);
  endtask

  task automatic t_clear();
    pulse_start();
    rd_access("R6 first after start", 1, 1'b0);
    rd_access("R6 coincident start", 1, 1'b1);
    rd_access("R6 after coincident", 1, 1'b0);
  endtask

  task automatic t_done();
    busy = 1'b0; arr_data = 8'h40;
    rd_access("R8 done true data", 1, 1'b0);
    arr_data = 8'h00;
    rd_access("R8 done no toggle", 1, 1'b0);
    repeat (3) @(negedge clk);
    busy = 1'b1; last_data = 8'hC3;
    rd_access("R8 resume poll", 1, 1'b0);
    rd_access("R8 resume poll 2", 1, 1'b0);
    busy = 1'b0;
  endtask

  initial begin
    t_reset();
    t_normal();
    t_gating();
    t_poll();
    t_hold();
    t_clear();
    t_done();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule